// File: doc/BRIEF.md
# Dual-Panel LCD Frame Fetch Address Generator

This block produces the word addresses from which an LCD controller fetches frame memory. It holds two address channels. The upper channel always serves the upper (or only) panel, and its buffer opens with a colour palette ahead of the pixel data. The lower channel is used only when split dual-panel operation is selected. It serves the lower half of the display, and its buffer holds pixel data alone, starting at its base address.

Software programs the two base addresses through a small register port while the display is disabled. When the display enable rises, each running address is loaded from its base. Every acknowledged fetch then moves the granted channel on by one 32-bit word. When a channel's next address would reach the end of its buffer, the channel reloads from its base, so the frame repeats. The end of each buffer is computed from the captured panel geometry and, for the upper channel, the palette size chosen by pixel depth. A single arbitrated fetch port presents one request at a time. The channel's own need signal says when it wants data.

The setup order for dual-panel operation is: drop enable, select dual mode and the geometry, write the upper base, write the lower base, then raise enable.

Top module: `lcd_dma_addr_gen`

## Requirements
- R1: After reset `fetch_req_o` is 0 until the display is enabled.
- R2: On the cycle in which `enable_i` goes from 0 to 1, both running addresses load from their bases and `fetch_req_o` is 0. Requests may start on the following cycle.
- R3: A cycle with `fetch_req_o`=1 and `fetch_ack_i`=1 advances the granted channel's running address by 4 and leaves the other channel unchanged.
- R4: When the granted channel's address plus 4 equals its end address, the channel reloads its base instead. End is base + frame bytes, with frame bytes = lines × words-per-line × 4. The upper channel also adds palette bytes: 32 when `depth8_i` was captured 0 (16 entries of 2 bytes) and 512 when it was captured 1 (256 entries).
- R5: `reg_rdata_o` shows, for `reg_addr_i` 0/1/2/3, the upper base, the lower base, the upper running address and the lower running address. Writes to addresses 2 and 3 have no effect. A running address changes only by an enable rise or an acknowledged fetch.
- R6: Base writes (`reg_we_i` with address 0 or 1) are ignored while `enable_i` is 1. `dual_i`, `depth8_i`, `lines_i` and `wpl_i` are captured on every cycle with `enable_i`=0 and are frozen while it is 1.
- R7: The lower channel is never granted while dual mode was captured 0.
- R8: The request rule is `fetch_req_o` = enabled-and-running AND (`need_i[0]` OR (dual AND `need_i[1]`)). `fetch_ch_o` is 0 for the upper channel and 1 for the lower channel, and `fetch_addr_o` is that channel's running address.
- R9: When both channels request, the upper channel wins first after an enable rise. Each acknowledged contended grant hands preference to the other channel. Uncontended grants leave the preference unchanged.
- R10: `fetch_req_o` falls in the same cycle that `enable_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Display enable |
| dual_i | input | 1 | Dual-panel select, captured while disabled |
| depth8_i | input | 1 | Large palette (256 entries) select, captured while disabled |
| lines_i | input | LINES_W | Lines per panel, captured while disabled |
| wpl_i | input | WPL_W | 32-bit words per line, captured while disabled |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Register read data |
| need_i | input | 2 | Per-channel data need, bit 0 upper, bit 1 lower |
| fetch_req_o | output | 1 | Fetch request |
| fetch_ch_o | output | 1 | Granted channel, 0 upper, 1 lower |
| fetch_addr_o | output | ADDR_W | Fetch word address |
| fetch_ack_i | input | 1 | Fetch accepted |

## Verification
Directed runs cover three kinds of traffic. Upper-only traffic in small-palette mode separates the 14-word upper wrap from the 6-word lower wrap. Steady contended traffic shows strict alternation starting with the upper channel. Single-panel mode with only the lower need raised must produce no request at all. A random phase then mixes need and acknowledge patterns with enable toggles, mode and geometry changes, and base writes both while enabled and while disabled. Comparing every cycle against a bench model tells a stuck preference apart from a wrong end address, a missed reload apart from a write that slipped through the lock, and a running address that moved without an acknowledge.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;
  localparam int unsigned PAL_ENTRIES_SMALL = 16;
  localparam int unsigned PAL_ENTRIES_LARGE = 256;
  localparam int unsigned PAL_ENTRY_BYTES   = 2;
  localparam int unsigned WORD_BYTES        = 4;
  localparam int unsigned NUM_CH            = 2;

  typedef enum logic {
    CH_UPPER = 1'b0,
    CH_LOWER = 1'b1
  } ch_sel_e;
endpackage

// File: rtl/lcd_dma_chan.sv
module lcd_dma_chan #(
  parameter int unsigned ADDR_W  = 32,
  parameter bit          HAS_PAL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] frame_bytes_i,
  input  logic [ADDR_W-1:0] pal_bytes_i,
  output logic [ADDR_W-1:0] cur_o
);
  import lcd_dma_pkg::*;

  logic [ADDR_W-1:0] span, end_addr, nxt, cur_q;

  generate
    if (HAS_PAL) begin : g_pal
      assign span = frame_bytes_i + pal_bytes_i;
    end else begin : g_nopal
      assign span = frame_bytes_i;
    end
  endgenerate

  assign end_addr = base_i + span;
  assign nxt      = cur_q + ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (load_i) cur_q <= base_i;
    else if (step_i) cur_q <= (nxt == end_addr) ? base_i : nxt;
  end

  assign cur_o = cur_q;

  // R5: running address moves only on load or acknowledged step
  assert_cur_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cur_q));
endmodule

// File: rtl/lcd_dma_arb.sv
module lcd_dma_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic [1:0] req_i,
  input  logic       ack_i,
  output logic [1:0] gnt_o
);
  logic pri_q;  // 1: lower channel preferred on contention

  assign gnt_o[1] = req_i[1] & (~req_i[0] | pri_q);
  assign gnt_o[0] = req_i[0] & ~gnt_o[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pri_q <= 1'b0;
    else if (clear_i)              pri_q <= 1'b0;
    else if (ack_i && (&req_i))    pri_q <= gnt_o[0];
  end

  assert_gnt_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_pri_alternate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (&req_i) && !clear_i) |=> (pri_q != $past(pri_q)));
endmodule

// File: rtl/lcd_dma_addr_gen.sv
module lcd_dma_addr_gen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINES_W = 10,
  parameter int unsigned WPL_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               dual_i,
  input  logic               depth8_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic [WPL_W-1:0]   wpl_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [ADDR_W-1:0]  reg_wdata_i,
  output logic [ADDR_W-1:0]  reg_rdata_o,
  input  logic [1:0]         need_i,
  output logic               fetch_req_o,
  output logic               fetch_ch_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  input  logic               fetch_ack_i
);
  import lcd_dma_pkg::*;

  localparam logic [ADDR_W-1:0] PAL_SMALL_B = ADDR_W'(PAL_ENTRIES_SMALL * PAL_ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] PAL_LARGE_B = ADDR_W'(PAL_ENTRIES_LARGE * PAL_ENTRY_BYTES);

  logic               en_q, dual_q, depth8_q;
  logic [LINES_W-1:0] lines_q;
  logic [WPL_W-1:0]   wpl_q;
  logic               en_rise, active;
  logic [ADDR_W-1:0]  frame_b, pal_b, frame_words;
  logic [ADDR_W-1:0]  base_q [NUM_CH];
  logic [ADDR_W-1:0]  cur    [NUM_CH];
  logic [1:0]         ch_req, gnt;

  assign en_rise = enable_i & ~en_q;
  assign active  = enable_i & en_q;

  // mode and geometry follow the inputs only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      dual_q   <= 1'b0;
      depth8_q <= 1'b0;
      lines_q  <= '0;
      wpl_q    <= '0;
    end else begin
      en_q <= enable_i;
      if (!enable_i) begin
        dual_q   <= dual_i;
        depth8_q <= depth8_i;
        lines_q  <= lines_i;
        wpl_q    <= wpl_i;
      end
    end
  end

  assign frame_words = ADDR_W'(lines_q) * ADDR_W'(wpl_q);
  assign frame_b     = {frame_words[ADDR_W-3:0], 2'b00};
  assign pal_b       = depth8_q ? PAL_LARGE_B : PAL_SMALL_B;

  assign ch_req[CH_UPPER] = active & need_i[CH_UPPER];
  assign ch_req[CH_LOWER] = active & need_i[CH_LOWER] & dual_q;

  lcd_dma_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(en_rise),
    .req_i  (ch_req),
    .ack_i  (fetch_ack_i),
    .gnt_o  (gnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        base_q[g] <= '0;
      else if (reg_we_i && !enable_i && (reg_addr_i == 2'(g)))
        base_q[g] <= reg_wdata_i;
    end

    lcd_dma_chan #(
      .ADDR_W (ADDR_W),
      .HAS_PAL(g == 0)
    ) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (en_rise),
      .step_i       (gnt[g] & fetch_ack_i),
      .base_i       (base_q[g]),
      .frame_bytes_i(frame_b),
      .pal_bytes_i  (pal_b),
      .cur_o        (cur[g])
    );
  end

  assign fetch_req_o  = |gnt;
  assign fetch_ch_o   = gnt[CH_LOWER];
  assign fetch_addr_o = gnt[CH_LOWER] ? cur[CH_LOWER] : cur[CH_UPPER];

  always_comb begin
    unique case (reg_addr_i)
      2'd0:    reg_rdata_o = base_q[0];
      2'd1:    reg_rdata_o = base_q[1];
      2'd2:    reg_rdata_o = cur[0];
      default: reg_rdata_o = cur[1];
    endcase
  end

  assert_no_req_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |-> !fetch_req_o);

  assert_base_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(base_q[0]) && $stable(base_q[1])));

  assert_lower_needs_dual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ch_o) |-> dual_q);

  assert_drop_on_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !fetch_req_o);
endmodule

// File: tb/lcd_dma_addr_gen_tb.sv
module lcd_dma_addr_gen_tb;
  localparam int AW = 32;
  localparam int LW = 10;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 0, dual = 0, depth8 = 0, we = 0, ack = 0;
  logic [LW-1:0] lines = 10'd2;
  logic [WW-1:0] wpl = 8'd3;
  logic [1:0]    raddr = 0, need = 0;
  logic [AW-1:0] wdata = 0, rdata, faddr;
  logic          freq, fch;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  bit            m_en, m_dual, m_d8, m_pri;
  int unsigned   m_lines, m_wpl;
  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_cur  [2];

  always #4 clk = ~clk;

  lcd_dma_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .dual_i(dual), .depth8_i(depth8),
    .lines_i(lines), .wpl_i(wpl), .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .need_i(need), .fetch_req_o(freq), .fetch_ch_o(fch),
    .fetch_addr_o(faddr), .fetch_ack_i(ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] end_of(input int ch);
    logic [AW-1:0] span;
    span = AW'(m_lines * m_wpl * 4);
    if (ch == 0) span += m_d8 ? 32'd512 : 32'd32;
    return m_base[ch] + span;
  endfunction

  function automatic bit exp_r(input int ch);
    if (!(m_en && enable)) return 0;
    return ch == 0 ? need[0] : (need[1] && m_dual);
  endfunction

  function automatic bit exp_g2();
    return exp_r(1) && (!exp_r(0) || m_pri);
  endfunction

  function automatic logic [AW-1:0] exp_rd();
    case (raddr)
      2'd0: return m_base[0];
      2'd1: return m_base[1];
      2'd2: return m_cur[0];
      default: return m_cur[1];
    endcase
  endfunction

  task automatic model_edge();
    bit r0, r1, g2, rise;
    r0 = exp_r(0); r1 = exp_r(1); g2 = exp_g2();
    rise = enable && !m_en;
    if (we && !enable && raddr < 2) m_base[raddr] = wdata;
    if (rise) begin
      m_cur[0] = m_base[0]; m_cur[1] = m_base[1]; m_pri = 0;
    end else if ((r0 || r1) && ack) begin
      int c = g2 ? 1 : 0;
      logic [AW-1:0] n = m_cur[c] + 4;
      m_cur[c] = (n == end_of(c)) ? m_base[c] : n;
      if (r0 && r1) m_pri = !g2;
    end
    if (!enable) begin
      m_dual = dual; m_d8 = depth8; m_lines = lines; m_wpl = wpl;
    end
    m_en = enable;
  endtask

  // called at a negedge with inputs already driven
  task automatic tick();
    bit er;
    #1;
    er = exp_r(0) || exp_r(1);
    chk(freq == er, "R8 req", AW'(freq), AW'(er));
    if (er) begin
      chk(fch == exp_g2(), "R9 ch", AW'(fch), AW'(exp_g2()));
      chk(faddr == (exp_g2() ? m_cur[1] : m_cur[0]), "R3 addr", faddr,
          exp_g2() ? m_cur[1] : m_cur[0]);
    end
    chk(rdata == exp_rd(), "R5 rdata", rdata, exp_rd());
    model_edge();
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, input logic [AW-1:0] exp, input string tag);
    raddr = a; we = 0; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
    we = 1; raddr = a; wdata = d; tick(); we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = 0; m_dual = 0; m_d8 = 0; m_pri = 0; m_lines = 0; m_wpl = 0;
    m_base[0] = 0; m_base[1] = 0; m_cur[0] = 0; m_cur[1] = 0;
    @(negedge clk); @(negedge clk);
    need = 2'b11; enable = 0;
    #1 chk(freq == 0, "R1 reset req", AW'(freq), 0);
    rst_n = 1;
    @(negedge clk);

    // setup: disabled, dual, small palette, 2 lines x 3 words
    dual = 1; depth8 = 0; need = 0;
    tick();
    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'h0000_8000);
    wr(2'd2, 32'h0000_5550);  // ignored: running address is read-only
    peek(2'd2, m_cur[0], "R5 ro write");

    // enable rise: no request, load from bases
    enable = 1; need = 2'b11; raddr = 2'd2;
    #1 chk(freq == 0, "R2 rise req", AW'(freq), 0);
    tick();
    peek(2'd2, 32'h0000_1000, "R2 load upper");
    peek(2'd3, 32'h0000_8000, "R2 load lower");

    // contended: upper first, then alternate
    ack = 1; #1;
    chk(freq && fch == 0, "R9 first upper", AW'(fch), 0);
    tick();
    #1 chk(fch == 1, "R9 then lower", AW'(fch), 1);
    tick();
    #1 chk(fch == 0, "R9 back upper", AW'(fch), 0);
    tick();

    // fresh frame, upper-only for 14 words: wraps to base
    enable = 0; ack = 0; need = 0; tick();
    enable = 1; tick();
    need = 2'b01; ack = 1;
    for (int i = 0; i < 13; i++) tick();
    peek(2'd2, 32'h0000_1000 + 13 * 4, "R4 before wrap");
    tick();
    peek(2'd2, 32'h0000_1000, "R4 upper wrap");
    peek(2'd3, 32'h0000_8000, "R3 other unchanged");
    need = 2'b10;
    for (int i = 0; i < 6; i++) tick();
    peek(2'd3, 32'h0000_8000, "R4 lower wrap");

    // locked while enabled
    need = 0; ack = 0;
    wr(2'd0, 32'h000D_EAD0);
    peek(2'd0, 32'h0000_1000, "R6 base locked");
    dual = 0; tick();
    need = 2'b10; #1;
    chk(freq == 1 && fch == 1, "R6 mode frozen", AW'(freq), 1);
    tick();

    // disable drops the request at once
    enable = 0; #1;
    chk(freq == 0, "R10 drop", AW'(freq), 0);
    tick();

    // single-panel: lower never requested
    enable = 1; tick();
    for (int i = 0; i < 8; i++) begin
      need = 2'b10; ack = 1; #1;
      chk(freq == 0, "R7 lower idle", AW'(freq), 0);
      tick();
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      need  = 2'($urandom);
      ack   = ($urandom % 4) != 0;
      raddr = 2'($urandom);
      we    = ($urandom % 8) == 0;
      wdata = {16'($urandom), 14'($urandom), 2'b00};
      if (($urandom % 150) == 0) enable = ~enable;
      if (!enable && ($urandom % 4) == 0) begin
        dual = $urandom; depth8 = $urandom;
        lines = LW'(1 + $urandom % 4); wpl = WW'(1 + $urandom % 4);
      end
      tick();
    end
    we = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule